// File: doc/BRIEF.md
# Memory Timing Parameter Legalizer

This unit turns bus timings requested in nanoseconds into cycle counts that a static memory controller can accept. A start request latches four requested times (address setup, strobe active, whole access cycle, and a data-float time picked by a speed-mode input) together with the clock frequency in hertz. Each time is converted to clock cycles with integer fixed-point arithmetic.

The controller accepts only gapped sets of values. The unit moves each count into its nearest legal value at or above the request. Any cycles added to setup or strobe are charged to the access cycle. The chip-select pulse must equal the access cycle and is bound by the strobe's legal ranges. When that forces the chip-select pulse upward, the cycle adopts the new value and the legalization runs again.

The final values are packed into the controller's compact field encodings and held, with saturation and error flags, until the next request.

Top module: `mem_timing_legalizer`

## Requirements
- R1: The multiplier is m = ((f / 10000) << 16) / 100000, using integer division, where f is `freq_hz_i`. A time of t ns becomes (t * m + 65536) >> 16 cycles.
- R2: Setup is legal in 0..31 and 128..159. A value in the gap is raised to 128. A value above 159 becomes 159 and sets `sat_o[0]`.
- R3: Strobe (pulse) is legal in 0..63 and 256..319. A value in the gap is raised to 256. A value above 319 becomes 319 and sets `sat_o[1]`.
- R4: The cycle count is first increased by every raise applied to setup and pulse. Raises that ended in saturation are not added. It is then legalized against 0..127, 256..383, 512..639 and 768..895. A gap value is raised to the next range start. A value above 895 becomes 895 and sets `sat_o[2]`.
- R5: The chip-select pulse starts equal to the legalized cycle. If it exceeds 319, `calc_err_o` is set and the unit stops.
- R6: The chip-select pulse is legalized against the R3 ranges. If this raises it, the cycle takes the raised value and the R2–R4 pass repeats. On an error-free finish, the decoded chip-select pulse equals the decoded cycle.
- R7: When the count of requested repeats reaches `MAX_ITER`, the unit stops and sets `loop_err_o`.
- R8: The float time is 20 ns when `fast_mode_i` is 1 and 30 ns otherwise, converted per R1. Counts above 15 are output as 15 and set `sat_o[4]`. `sat_o[3]` flags saturation of the chip-select pulse.
- R9: Setup is encoded as {v[7], v[4:0]}. Pulse and chip-select pulse are encoded as {v[8], v[5:0]}. Cycle is encoded as {v[9:8], v[6:0]}.
- R10: `start_i` is taken only while `busy_o` is 0. `busy_o` stays 1 until `done_o` rises. A second `start_i` during busy has no effect on the result. While `done_o` is 1, it and all result outputs hold until the next accepted start.
- R11: After reset, `busy_o`, `done_o`, every result field and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a legalization run |
| freq_hz_i | input | F_W | Clock frequency in Hz |
| setup_ns_i | input | NS_W | Requested setup time, ns |
| pulse_ns_i | input | NS_W | Requested strobe active time, ns |
| cycle_ns_i | input | NS_W | Requested total access time, ns |
| fast_mode_i | input | 1 | Selects the 20 ns float time |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Results valid and held |
| setup_enc_o | output | 6 | Encoded setup |
| pulse_enc_o | output | 7 | Encoded strobe pulse |
| cycle_enc_o | output | 9 | Encoded access cycle |
| cs_pulse_enc_o | output | 7 | Encoded chip-select pulse |
| float_cyc_o | output | 4 | Float cycles |
| sat_o | output | 5 | Saturation: setup, pulse, cycle, cs, float |
| calc_err_o | output | 1 | Chip-select pulse exceeds 319 |
| loop_err_o | output | 1 | Repeat limit reached |

## Verification
The bench builds two copies side by side. One uses the default `MAX_ITER` of 4, which comfortably covers the single repeat the chip-select raise needs. The other uses `MAX_ITER` of 1, so that the same raise drives the repeat-limit error. Most stimuli run at 1 GHz, where the multiplier is exactly 65536 and a time of t ns becomes t+1 cycles. This makes it easy to place values in each gap, above each top range, and past the 319 chip-select limit. A 100 MHz case exercises the truncating multiplier and the rounding.

// File: rtl/tml_pkg.sv
package tml_pkg;
  localparam int SETUP_SPAN   = 32;
  localparam int SETUP_STRIDE = 128;
  localparam int SETUP_CNT    = 2;
  localparam int PULSE_SPAN   = 64;
  localparam int PULSE_STRIDE = 256;
  localparam int PULSE_CNT    = 2;
  localparam int CYCLE_SPAN   = 128;
  localparam int CYCLE_STRIDE = 256;
  localparam int CYCLE_CNT    = 4;
  localparam int CS_LIMIT     = 319;
  localparam int FLOAT_MAX    = 15;
  localparam int FLOAT_SLOW_NS = 30;
  localparam int FLOAT_FAST_NS = 20;

  localparam int SETUP_ENC_W = 6;
  localparam int PULSE_ENC_W = 7;
  localparam int CYCLE_ENC_W = 9;
  localparam int FLOAT_W     = 4;
  localparam int SAT_W       = 5;

  localparam int SAT_SETUP = 0;
  localparam int SAT_PULSE = 1;
  localparam int SAT_CYCLE = 2;
  localparam int SAT_CS    = 3;
  localparam int SAT_FLOAT = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV, ST_SNAP_SP, ST_SNAP_CY, ST_SNAP_CS, ST_PACK, ST_DONE
  } state_e;
endpackage

// File: rtl/tml_ns2cyc.sv
module tml_ns2cyc #(
  parameter int NS_W  = 16,
  parameter int M_W   = 20,
  parameter int CYC_W = 20
) (
  input  logic [M_W-1:0]   mul_i,
  input  logic [NS_W-1:0]  ns_i,
  output logic [CYC_W-1:0] cyc_o
);
  localparam int P_W = NS_W + M_W + 1;

  logic [P_W-1:0] prod;
  logic           spare_bits;

  always_comb begin
    prod  = P_W'(ns_i) * P_W'(mul_i) + P_W'(65536);
    cyc_o = prod[16 +: CYC_W];
  end

  assign spare_bits = ^{prod[15:0], prod[P_W-1:16+CYC_W]};
endmodule

// File: rtl/tml_range_snap.sv
module tml_range_snap #(
  parameter int W      = 22,
  parameter int SPAN   = 32,
  parameter int STRIDE = 128,
  parameter int CNT    = 2
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] val_o,
  output logic         sat_o
);
  localparam int SH  = $clog2(STRIDE);
  localparam int KW  = W - SH;
  localparam int TOP = (CNT - 1) * STRIDE + SPAN - 1;

  logic [KW-1:0] k;
  logic [SH-1:0] off;

  always_comb begin
    k     = v_i[W-1:SH];
    off   = v_i[SH-1:0];
    val_o = v_i;
    sat_o = 1'b0;
    if (k >= KW'(CNT)) begin
      val_o = W'(TOP);
      sat_o = 1'b1;
    end else if ({1'b0, off} >= (SH+1)'(SPAN)) begin
      // in a gap: next range start, or clamp after the last range
      if ((k + KW'(1)) < KW'(CNT)) begin
        val_o = {k + KW'(1), {SH{1'b0}}};
      end else begin
        val_o = W'(TOP);
        sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tml_encode.sv
module tml_encode #(
  parameter int W = 22
) (
  input  logic [W-1:0] setup_i,
  input  logic [W-1:0] pulse_i,
  input  logic [W-1:0] cycle_i,
  input  logic [W-1:0] cs_i,
  output logic [5:0]   setup_o,
  output logic [6:0]   pulse_o,
  output logic [8:0]   cycle_o,
  output logic [6:0]   cs_o
);
  logic spare_bits;

  assign setup_o = {setup_i[7], setup_i[4:0]};
  assign pulse_o = {pulse_i[8], pulse_i[5:0]};
  assign cs_o    = {cs_i[8], cs_i[5:0]};
  assign cycle_o = {cycle_i[9:8], cycle_i[6:0]};

  assign spare_bits = ^{setup_i[W-1:8], setup_i[6:5],
                        pulse_i[W-1:9], pulse_i[7:6],
                        cs_i[W-1:9], cs_i[7:6],
                        cycle_i[W-1:10], cycle_i[7]};
endmodule

// File: rtl/mem_timing_legalizer.sv
module mem_timing_legalizer
  import tml_pkg::*;
#(
  parameter int F_W      = 32,
  parameter int NS_W     = 16,
  parameter int CYC_W    = 20,
  parameter int MAX_ITER = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [F_W-1:0]   freq_hz_i,
  input  logic [NS_W-1:0]  setup_ns_i,
  input  logic [NS_W-1:0]  pulse_ns_i,
  input  logic [NS_W-1:0]  cycle_ns_i,
  input  logic             fast_mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [5:0]       setup_enc_o,
  output logic [6:0]       pulse_enc_o,
  output logic [8:0]       cycle_enc_o,
  output logic [6:0]       cs_pulse_enc_o,
  output logic [3:0]       float_cyc_o,
  output logic [4:0]       sat_o,
  output logic             calc_err_o,
  output logic             loop_err_o
);
  localparam int M_W  = F_W - 12;
  localparam int CW   = CYC_W + 2;
  localparam int PW   = $clog2(MAX_ITER + 1);
  localparam int N_IN = 4;

  state_e           state_q;
  logic [F_W-1:0]   freq_q;
  logic [NS_W-1:0]  ns_q [N_IN];
  logic [CYC_W-1:0] conv [N_IN];
  logic [F_W+15:0]  mul_wide;
  logic [M_W-1:0]   mul;
  logic             spare_bits;

  logic [CW-1:0]    setup_q, pulse_q, cyc_q, cs_q;
  logic [3:0]       float_q;
  logic [4:0]       sat_q;
  logic             cerr_q, lerr_q;
  logic [PW-1:0]    pass_q;

  logic [CW-1:0]    s_val, p_val, c_val, cs_val;
  logic             s_sat, p_sat, c_sat, cs_sat;
  logic [CW-1:0]    cyc_add;
  logic [5:0]       setup_e;
  logic [6:0]       pulse_e, cs_e;
  logic [8:0]       cycle_e;

  // fixed-point multiplier, frequency scaled to cycles per ns << 16
  always_comb begin
    mul_wide = ((F_W+16)'(freq_q / F_W'(10000)) << 16) / (F_W+16)'(100000);
    mul      = mul_wide[M_W-1:0];
  end
  assign spare_bits = ^mul_wide[F_W+15:M_W];

  for (genvar g = 0; g < N_IN; g++) begin : g_conv
    tml_ns2cyc #(.NS_W(NS_W), .M_W(M_W), .CYC_W(CYC_W)) u_conv (
      .mul_i(mul), .ns_i(ns_q[g]), .cyc_o(conv[g])
    );
  end

  tml_range_snap #(.W(CW), .SPAN(SETUP_SPAN), .STRIDE(SETUP_STRIDE), .CNT(SETUP_CNT))
    u_snap_setup (.v_i(setup_q), .val_o(s_val), .sat_o(s_sat));
  tml_range_snap #(.W(CW), .SPAN(PULSE_SPAN), .STRIDE(PULSE_STRIDE), .CNT(PULSE_CNT))
    u_snap_pulse (.v_i(pulse_q), .val_o(p_val), .sat_o(p_sat));
  tml_range_snap #(.W(CW), .SPAN(CYCLE_SPAN), .STRIDE(CYCLE_STRIDE), .CNT(CYCLE_CNT))
    u_snap_cycle (.v_i(cyc_q), .val_o(c_val), .sat_o(c_sat));
  tml_range_snap #(.W(CW), .SPAN(PULSE_SPAN), .STRIDE(PULSE_STRIDE), .CNT(PULSE_CNT))
    u_snap_cs (.v_i(cs_q), .val_o(cs_val), .sat_o(cs_sat));

  tml_encode #(.W(CW)) u_enc (
    .setup_i(setup_q), .pulse_i(pulse_q), .cycle_i(cyc_q), .cs_i(cs_q),
    .setup_o(setup_e), .pulse_o(pulse_e), .cycle_o(cycle_e), .cs_o(cs_e)
  );

  // raises charged to the cycle; a clamp is never charged
  always_comb begin
    cyc_add = cyc_q;
    if (!s_sat) cyc_add = cyc_add + (s_val - setup_q);
    if (!p_sat) cyc_add = cyc_add + (p_val - pulse_q);
  end

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      freq_q         <= '0;
      for (int i = 0; i < N_IN; i++) ns_q[i] <= '0;
      setup_q        <= '0;
      pulse_q        <= '0;
      cyc_q          <= '0;
      cs_q           <= '0;
      float_q        <= '0;
      sat_q          <= '0;
      cerr_q         <= 1'b0;
      lerr_q         <= 1'b0;
      pass_q         <= '0;
      setup_enc_o    <= '0;
      pulse_enc_o    <= '0;
      cycle_enc_o    <= '0;
      cs_pulse_enc_o <= '0;
      float_cyc_o    <= '0;
      sat_o          <= '0;
      calc_err_o     <= 1'b0;
      loop_err_o     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            freq_q  <= freq_hz_i;
            ns_q[0] <= setup_ns_i;
            ns_q[1] <= pulse_ns_i;
            ns_q[2] <= cycle_ns_i;
            ns_q[3] <= fast_mode_i ? NS_W'(FLOAT_FAST_NS) : NS_W'(FLOAT_SLOW_NS);
            sat_q   <= '0;
            cerr_q  <= 1'b0;
            lerr_q  <= 1'b0;
            pass_q  <= '0;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          setup_q <= CW'(conv[0]);
          pulse_q <= CW'(conv[1]);
          cyc_q   <= CW'(conv[2]);
          if (conv[3] > CYC_W'(FLOAT_MAX)) begin
            float_q          <= 4'(FLOAT_MAX);
            sat_q[SAT_FLOAT] <= 1'b1;
          end else begin
            float_q <= conv[3][3:0];
          end
          state_q <= ST_SNAP_SP;
        end
        ST_SNAP_SP: begin
          setup_q          <= s_val;
          pulse_q          <= p_val;
          cyc_q            <= cyc_add;
          sat_q[SAT_SETUP] <= sat_q[SAT_SETUP] | s_sat;
          sat_q[SAT_PULSE] <= sat_q[SAT_PULSE] | p_sat;
          state_q          <= ST_SNAP_CY;
        end
        ST_SNAP_CY: begin
          cyc_q            <= c_val;
          cs_q             <= c_val;
          sat_q[SAT_CYCLE] <= sat_q[SAT_CYCLE] | c_sat;
          if (c_val > CW'(CS_LIMIT)) begin
            cerr_q  <= 1'b1;
            state_q <= ST_PACK;
          end else begin
            state_q <= ST_SNAP_CS;
          end
        end
        ST_SNAP_CS: begin
          cs_q          <= cs_val;
          sat_q[SAT_CS] <= sat_q[SAT_CS] | cs_sat;
          if (cs_val != cs_q) begin
            cyc_q <= cs_val;
            if (pass_q == PW'(MAX_ITER - 1)) begin
              lerr_q  <= 1'b1;
              state_q <= ST_PACK;
            end else begin
              pass_q  <= pass_q + PW'(1);
              state_q <= ST_SNAP_SP;
            end
          end else begin
            state_q <= ST_PACK;
          end
        end
        ST_PACK: begin
          setup_enc_o    <= setup_e;
          pulse_enc_o    <= pulse_e;
          cycle_enc_o    <= cycle_e;
          cs_pulse_enc_o <= cs_e;
          float_cyc_o    <= float_q;
          sat_o          <= sat_q;
          calc_err_o     <= cerr_q;
          loop_err_o     <= lerr_q;
          state_q        <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tml_checker.sv
module tml_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [5:0] setup_enc_o,
  input logic [6:0] pulse_enc_o,
  input logic [8:0] cycle_enc_o,
  input logic [6:0] cs_pulse_enc_o,
  input logic [3:0] float_cyc_o,
  input logic [4:0] sat_o,
  input logic       calc_err_o,
  input logic       loop_err_o
);
  logic [9:0] cyc_dec, cs_dec;
  assign cyc_dec = {cycle_enc_o[8:7], 1'b0, cycle_enc_o[6:0]};
  assign cs_dec  = {1'b0, cs_pulse_enc_o[6], 2'b00, cs_pulse_enc_o[5:0]};

  p_busy_done_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_start_taken_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_done_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(setup_enc_o) && $stable(pulse_enc_o)
      && $stable(cycle_enc_o) && $stable(cs_pulse_enc_o) && $stable(float_cyc_o)
      && $stable(sat_o) && $stable(calc_err_o) && $stable(loop_err_o)));

  p_cs_eq_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !calc_err_o && !loop_err_o) |-> (cs_dec == cyc_dec));

  p_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(calc_err_o && loop_err_o));

  p_float_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sat_o[4]) |-> (float_cyc_o == 4'd15));
endmodule

bind mem_timing_legalizer tml_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .setup_enc_o(setup_enc_o), .pulse_enc_o(pulse_enc_o),
  .cycle_enc_o(cycle_enc_o), .cs_pulse_enc_o(cs_pulse_enc_o),
  .float_cyc_o(float_cyc_o), .sat_o(sat_o), .calc_err_o(calc_err_o),
  .loop_err_o(loop_err_o)
);

// File: tb/mem_timing_legalizer_test.sv
module mem_timing_legalizer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freq = '0;
  logic [15:0] s_ns = '0, p_ns = '0, c_ns = '0;
  logic        fast = 1'b0;

  logic       busy_a, done_a, cerr_a, lerr_a;
  logic [5:0] se_a;
  logic [6:0] pe_a, cse_a;
  logic [8:0] ce_a;
  logic [3:0] fl_a;
  logic [4:0] sat_a;
  logic       busy_b, done_b, cerr_b, lerr_b;
  logic [5:0] se_b;
  logic [6:0] pe_b, cse_b;
  logic [8:0] ce_b;
  logic [3:0] fl_b;
  logic [4:0] sat_b;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mem_timing_legalizer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_hz_i(freq),
    .setup_ns_i(s_ns), .pulse_ns_i(p_ns), .cycle_ns_i(c_ns), .fast_mode_i(fast),
    .busy_o(busy_a), .done_o(done_a), .setup_enc_o(se_a), .pulse_enc_o(pe_a),
    .cycle_enc_o(ce_a), .cs_pulse_enc_o(cse_a), .float_cyc_o(fl_a), .sat_o(sat_a),
    .calc_err_o(cerr_a), .loop_err_o(lerr_a)
  );

  mem_timing_legalizer #(.MAX_ITER(1)) uut_lim (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_hz_i(freq),
    .setup_ns_i(s_ns), .pulse_ns_i(p_ns), .cycle_ns_i(c_ns), .fast_mode_i(fast),
    .busy_o(busy_b), .done_o(done_b), .setup_enc_o(se_b), .pulse_enc_o(pe_b),
    .cycle_enc_o(ce_b), .cs_pulse_enc_o(cse_b), .float_cyc_o(fl_b), .sat_o(sat_b),
    .calc_err_o(cerr_b), .loop_err_o(lerr_b)
  );

  typedef struct {
    int s_enc; int p_enc; int c_enc; int cs_enc; int fl; int sat; int cerr; int lerr;
  } exp_t;
  typedef int rng_t [4];

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // returns -1 when clamped, else the raise
  function automatic int snap(inout int v, input rng_t lo, input rng_t hi, input int n);
    for (int i = 0; i < n; i++) begin
      if (v < lo[i]) begin
        int d = lo[i] - v;
        v = lo[i];
        return d;
      end
      if (v <= hi[i]) return 0;
    end
    v = hi[n-1];
    return -1;
  endfunction

  function automatic longint to_cyc(longint f, longint ns);
    longint m = ((f / 10000) << 16) / 100000;
    return (ns * m + 65536) >> 16;
  endfunction

  function automatic exp_t model(longint f, int sn, int pn, int cn, bit fst, int max_iter);
    rng_t slo = '{0, 128, 0, 0},   shi = '{31, 159, 0, 0};
    rng_t plo = '{0, 256, 0, 0},   phi = '{63, 319, 0, 0};
    rng_t clo = '{0, 256, 512, 768}, chi = '{127, 383, 639, 895};
    exp_t e = '{default: 0};
    int s = int'(to_cyc(f, sn));
    int p = int'(to_cyc(f, pn));
    int c = int'(to_cyc(f, cn));
    int fl = int'(to_cyc(f, fst ? 20 : 30));
    int cs = 0;
    int passes = 0;
    int r;
    if (fl > 15) begin fl = 15; e.sat |= 16; end
    forever begin
      r = snap(s, slo, shi, 2); if (r < 0) e.sat |= 1; else c += r;
      r = snap(p, plo, phi, 2); if (r < 0) e.sat |= 2; else c += r;
      r = snap(c, clo, chi, 4); if (r < 0) e.sat |= 4;
      cs = c;
      if (cs > 319) begin e.cerr = 1; break; end
      r = snap(cs, plo, phi, 2);
      if (r < 0) e.sat |= 8;
      if (r > 0) begin
        c = cs; passes++;
        if (passes == max_iter) begin e.lerr = 1; break; end
      end else break;
    end
    e.s_enc  = (s & 31) | ((s & 128) >> 2);
    e.p_enc  = (p & 63) | ((p & 256) >> 2);
    e.cs_enc = (cs & 63) | ((cs & 256) >> 2);
    e.c_enc  = (c & 127) | ((c & 768) >> 1);
    e.fl     = fl;
    return e;
  endfunction

  task automatic check_both(string req, exp_t ea, exp_t eb);
    check(req, "done", done_a, 1);       check(req, "busy", busy_a, 0);
    check(req, "setup_enc", se_a, ea.s_enc);  check(req, "pulse_enc", pe_a, ea.p_enc);
    check(req, "cycle_enc", ce_a, ea.c_enc);  check(req, "cs_enc", cse_a, ea.cs_enc);
    check(req, "float", fl_a, ea.fl);     check(req, "sat", sat_a, ea.sat);
    check(req, "calc_err", cerr_a, ea.cerr);  check(req, "loop_err", lerr_a, ea.lerr);
    check(req, "lim done", done_b, 1);
    check(req, "lim setup_enc", se_b, eb.s_enc);  check(req, "lim pulse_enc", pe_b, eb.p_enc);
    check(req, "lim cycle_enc", ce_b, eb.c_enc);  check(req, "lim cs_enc", cse_b, eb.cs_enc);
    check(req, "lim float", fl_b, eb.fl);     check(req, "lim sat", sat_b, eb.sat);
    check(req, "lim calc_err", cerr_b, eb.cerr);  check(req, "lim loop_err", lerr_b, eb.lerr);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 64 && !(done_a && done_b); i++) @(negedge clk);
  endtask

  task automatic run(string req, longint f, int sn, int pn, int cn, bit fst);
    @(negedge clk);
    freq = 32'(f); s_ns = 16'(sn); p_ns = 16'(pn); c_ns = 16'(cn); fast = fst;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_both(req, model(f, sn, pn, cn, fst, 4), model(f, sn, pn, cn, fst, 1));
  endtask

  task automatic t_reset();
    check("R11", "busy", busy_a, 0);   check("R11", "done", done_a, 0);
    check("R11", "setup_enc", se_a, 0); check("R11", "cycle_enc", ce_a, 0);
    check("R11", "cs_enc", cse_a, 0);  check("R11", "sat", sat_a, 0);
    check("R11", "errs", {cerr_a, lerr_a}, 0);
  endtask

  task automatic t_convert();
    run("R1", 100_000_000, 70, 290, 600, 1'b0);
    check("R1", "setup 70ns@100MHz", se_a, 7);
    check("R8", "float slow@100MHz", fl_a, 3);
    run("R8", 100_000_000, 70, 290, 600, 1'b1);
    check("R8", "float fast@100MHz", fl_a, 2);
  endtask

  task automatic t_setup_gap();
    run("R2", 1_000_000_000, 49, 20, 99, 1'b0);
    check("R2", "setup raised to 128", se_a, 32);
    check("R4", "cycle 178 -> 256", ce_a, 128);
    check("R8", "float sat flag", sat_a[4], 1);
  endtask

  task automatic t_pulse_gap();
    run("R3", 1_000_000_000, 5, 99, 40, 1'b1);
    check("R3", "pulse raised to 256", pe_a, 64);
    check("R4", "cycle 197 -> 256", ce_a, 128);
  endtask

  task automatic t_cs_loop();
    run("R6", 1_000_000_000, 9, 9, 99, 1'b0);
    check("R6", "cs 100 -> 256", cse_a, 64);
    check("R6", "cycle follows cs", ce_a, 128);
    check("R7", "limit 1 loop_err", lerr_b, 1);
    check("R7", "limit 4 no loop_err", lerr_a, 0);
  endtask

  task automatic t_calc_err();
    run("R5", 1_000_000_000, 9, 9, 330, 1'b0);
    check("R5", "cs > 319 error", cerr_a, 1);
  endtask

  task automatic t_saturate();
    run("R2", 1_000_000_000, 300, 500, 9, 1'b0);
    check("R2", "setup sat flag", sat_a[0], 1);
    check("R3", "pulse sat flag", sat_a[1], 1);
    check("R4", "no charge on clamp", ce_a, 10);
    run("R4", 1_000_000_000, 9, 9, 999, 1'b0);
    check("R4", "cycle sat flag", sat_a[2], 1);
    check("R5", "clamped cycle errors", cerr_a, 1);
  endtask

  task automatic t_pack();
    run("R9", 1_000_000_000, 139, 299, 299, 1'b0);
    check("R9", "setup 140", se_a, 44);
    check("R9", "pulse 300", pe_a, 108);
    check("R9", "cycle 300", ce_a, 172);
    check("R9", "cs 300", cse_a, 108);
  endtask

  task automatic t_handshake();
    exp_t ea = model(1_000_000_000, 49, 20, 99, 1'b0, 4);
    exp_t eb = model(1_000_000_000, 49, 20, 99, 1'b0, 1);
    @(negedge clk);
    freq = 1_000_000_000; s_ns = 49; p_ns = 20; c_ns = 99; fast = 1'b0;
    start = 1'b1;
    @(negedge clk);
    check("R10", "busy after start", busy_a, 1);
    s_ns = 139; p_ns = 299; c_ns = 299;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_both("R10", ea, eb);
    freq = 100_000_000; s_ns = 1; c_ns = 1; fast = 1'b1;
    repeat (6) @(negedge clk);
    check_both("R10", ea, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_convert();
    t_setup_gap();
    t_pulse_gap();
    t_cs_loop();
    t_calc_err();
    t_saturate();
    t_pack();
    t_handshake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule